// File: doc/BRIEF.md
# Mode-Banked Register File

This block stores the architectural registers of a small 32-bit processor core. It does not decode instructions and does not hold the live status flags. It holds the registers and sends every access to the right physical copy. A 4-bit register index selects a register. The physical copy that the index reaches depends on the 5-bit operating-mode input. Some indices are shared by every mode, some have a private copy per exception mode, and the program counter exists once.

There are two read ports and one write port for the indexed registers, and one port for the saved status register of the current mode. Reads are synchronous: the value for an index presented at a clock edge shows up on the output after that edge. When the core is in a privileged mode, a user-bank flag sends the indexed reads and the write to the copies that user mode sees. This lets a handler save and restore another context's registers.

The storage is a 31-entry, two-read, one-write memory that can map onto block RAM, plus five saved status flops. The current status register lives outside this block. Together they make up the 37 registers of the programming model.

Top module: `banked_regfile`

## Requirements
- R1: While reset is high, and in the cycle after a reset edge, both read data outputs and the saved status output read zero. The five saved status registers are cleared to zero.
- R2: An index and mode presented at a rising edge produce their read data on the output right after that edge, one cycle of latency.
- R3: Indices 0 to 7 reach one physical copy each, shared by every mode.
- R4: In FIQ mode (10001), indices 8 to 12 reach copies private to that mode. Every other mode reaches the user copies for 8 to 12.
- R5: Indices 13 and 14 have a private copy in each of FIQ, IRQ (10010), supervisor (10011), abort (10111) and undefined (11011) mode. User (10000) and system (11111) mode share one copy.
- R6: Index 15 is a single program counter shared by all modes. A read returns exactly the stored value, with no offset added.
- R7: A mode value other than the seven listed encodings is handled as user mode for register selection and for saved status access.
- R8: When the user-bank flag is high in a privileged mode (any listed mode except user), reads and writes of indices 8 to 14 reach the user copies. The private copies are left unchanged.
- R9: Each of the five exception modes has its own saved status register, read and written through the status port. In user, system or an unknown mode, a status write is ignored and the status output reads zero.
- R10: A read of a register in the same cycle as a write to it returns the old value. The new value is returned from the next cycle on. This holds for both read ports and for the status port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 5 | Current operating mode encoding |
| user_bank | input | 1 | In a privileged mode, send indexed accesses to the user copies |
| rd_a_idx | input | 4 | Read port A register index |
| rd_a_data | output | 32 | Read port A data, registered |
| rd_b_idx | input | 4 | Read port B register index |
| rd_b_data | output | 32 | Read port B data, registered |
| wr_en | input | 1 | Indexed write enable |
| wr_idx | input | 4 | Indexed write register index |
| wr_data | input | 32 | Indexed write data |
| sr_wr_en | input | 1 | Saved status write enable for the current mode |
| sr_wr_data | input | 32 | Saved status write data |
| sr_rd_data | output | 32 | Saved status of the current mode, registered |

## Verification
On every cycle, the assertions check where indices are steered: shared low indices, the single program counter, the user copies of 8 to 12 outside FIQ mode, and private 13/14 copies in exception modes. They also check that the saved status registers hold still when no valid status write occurs, and that a value written while being read appears one cycle later. Only the bench scenarios can show that the data is actually kept apart between modes. Those scenarios cover copies written in one mode and read back in another, the user-bank flag reaching user copies while leaving private ones alone, status writes ignored in unprivileged modes, and unknown mode values folding to user mode.

// File: rtl/banked_regfile_pkg.sv
package banked_regfile_pkg;

  typedef enum logic [2:0] {
    BK_USR = 3'd0,
    BK_FIQ = 3'd1,
    BK_IRQ = 3'd2,
    BK_SVC = 3'd3,
    BK_ABT = 3'd4,
    BK_UND = 3'd5
  } bank_e;

  localparam logic [4:0] MD_USR = 5'b10000;
  localparam logic [4:0] MD_FIQ = 5'b10001;
  localparam logic [4:0] MD_IRQ = 5'b10010;
  localparam logic [4:0] MD_SVC = 5'b10011;
  localparam logic [4:0] MD_ABT = 5'b10111;
  localparam logic [4:0] MD_UND = 5'b11011;
  localparam logic [4:0] MD_SYS = 5'b11111;

  // Physical layout: 0..14 user view, 15 program counter,
  // 16..20 FIQ copies of 8..12, then one 13/14 pair per exception bank.
  localparam int NUM_SLOTS    = 31;
  localparam int PC_SLOT      = 15;
  localparam int FIQ_LO_BASE  = 16;
  localparam int PAIR_BASE    = 21;
  localparam int NUM_EXC      = 5;

  function automatic bank_e mode_to_bank(input logic [4:0] m);
    case (m)
      MD_FIQ:  return BK_FIQ;
      MD_IRQ:  return BK_IRQ;
      MD_SVC:  return BK_SVC;
      MD_ABT:  return BK_ABT;
      MD_UND:  return BK_UND;
      default: return BK_USR;
    endcase
  endfunction

  function automatic logic mode_is_priv(input logic [4:0] m);
    case (m)
      MD_FIQ, MD_IRQ, MD_SVC, MD_ABT, MD_UND, MD_SYS: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/banked_regfile_map.sv
module banked_regfile_map
  import banked_regfile_pkg::*;
#(
  parameter int IDX_W  = 4,
  parameter int SLOT_W = 5
) (
  input  bank_e             bank,
  input  logic [IDX_W-1:0]  idx,
  output logic [SLOT_W-1:0] slot
);
  localparam int LO_SHARED = 8;
  localparam int LO_BANKED_TOP = 12;
  localparam int SP_IDX = 13;

  always_comb begin
    slot = SLOT_W'(idx);
    if (idx == IDX_W'(PC_SLOT)) begin
      slot = SLOT_W'(PC_SLOT);
    end else if (int'(idx) < LO_SHARED) begin
      slot = SLOT_W'(idx);
    end else if (int'(idx) <= LO_BANKED_TOP) begin
      if (bank == BK_FIQ)
        slot = SLOT_W'(FIQ_LO_BASE + int'(idx) - LO_SHARED);
    end else begin
      if (bank != BK_USR)
        slot = SLOT_W'(PAIR_BASE + 2 * (int'(bank) - 1) + int'(idx) - SP_IDX);
    end
  end

endmodule

// File: rtl/banked_regfile_mem.sv
module banked_regfile_mem #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 31,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] wa,
  input  logic [DATA_W-1:0] wd,
  input  logic [ADDR_W-1:0] ra,
  input  logic [ADDR_W-1:0] rb,
  output logic [DATA_W-1:0] qa,
  output logic [DATA_W-1:0] qb
);
  logic [DATA_W-1:0] mem [DEPTH];

  // Read-first: the registered read sees the contents before this edge's write.
  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      qa <= '0;
      qb <= '0;
    end else begin
      qa <= mem[ra];
      qb <= mem[rb];
    end
  end

  // R10
  new_value_next_chk: assert property (@(posedge clk) disable iff (rst)
    (we && ra == wa) ##1 (!we && ra == $past(ra)) |=> qa == $past(wd, 2));

endmodule

// File: rtl/banked_regfile_status.sv
module banked_regfile_status #(
  parameter int DATA_W = 32,
  parameter int NUM    = 5,
  parameter int SEL_W  = $clog2(NUM)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid,
  input  logic [SEL_W-1:0]  sel,
  input  logic              we,
  input  logic [DATA_W-1:0] wd,
  output logic [DATA_W-1:0] q
);
  logic [NUM-1:0][DATA_W-1:0] regs;

  for (genvar g = 0; g < NUM; g++) begin : g_sr
    always_ff @(posedge clk) begin
      if (rst)
        regs[g] <= '0;
      else if (we && valid && sel == SEL_W'(g))
        regs[g] <= wd;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           q <= '0;
    else if (valid)    q <= regs[sel];
    else               q <= '0;
  end

  // R9
  no_stray_sr_write_chk: assert property (@(posedge clk) disable iff (rst)
    !(we && valid) |=> $stable(regs));

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import banked_regfile_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [4:0]        mode,
  input  logic              user_bank,
  input  logic [IDX_W-1:0]  rd_a_idx,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [IDX_W-1:0]  rd_b_idx,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              sr_wr_en,
  input  logic [DATA_W-1:0] sr_wr_data,
  output logic [DATA_W-1:0] sr_rd_data
);
  localparam int SLOT_W = $clog2(NUM_SLOTS);
  localparam int SEL_W  = $clog2(NUM_EXC);
  localparam int PORTS  = 3;

  bank_e mode_bank, acc_bank;
  logic  priv;
  logic [IDX_W-1:0]  port_idx  [PORTS];
  logic [SLOT_W-1:0] port_slot [PORTS];
  logic [SEL_W-1:0]  sr_sel;
  logic              sr_valid;

  always_comb begin
    mode_bank = mode_to_bank(mode);
    priv      = mode_is_priv(mode);
    acc_bank  = (priv && user_bank) ? BK_USR : mode_bank;
    sr_valid  = (mode_bank != BK_USR);
    sr_sel    = sr_valid ? SEL_W'(int'(mode_bank) - 1) : '0;
  end

  assign port_idx[0] = rd_a_idx;
  assign port_idx[1] = rd_b_idx;
  assign port_idx[2] = wr_idx;

  for (genvar p = 0; p < PORTS; p++) begin : g_map
    banked_regfile_map #(.IDX_W(IDX_W), .SLOT_W(SLOT_W)) u_map (
      .bank (acc_bank),
      .idx  (port_idx[p]),
      .slot (port_slot[p])
    );
  end

  banked_regfile_mem #(.DATA_W(DATA_W), .DEPTH(NUM_SLOTS), .ADDR_W(SLOT_W)) u_mem (
    .clk (clk),
    .rst (rst),
    .we  (wr_en),
    .wa  (port_slot[2]),
    .wd  (wr_data),
    .ra  (port_slot[0]),
    .rb  (port_slot[1]),
    .qa  (rd_a_data),
    .qb  (rd_b_data)
  );

  banked_regfile_status #(.DATA_W(DATA_W), .NUM(NUM_EXC), .SEL_W(SEL_W)) u_sr (
    .clk   (clk),
    .rst   (rst),
    .valid (sr_valid),
    .sel   (sr_sel),
    .we    (sr_wr_en),
    .wd    (sr_wr_data),
    .q     (sr_rd_data)
  );

  // R6
  pc_single_chk: assert property (@(posedge clk) disable iff (rst)
    rd_a_idx == IDX_W'(15) |-> port_slot[0] == SLOT_W'(PC_SLOT));

  // R3
  low_shared_chk: assert property (@(posedge clk) disable iff (rst)
    rd_a_idx < IDX_W'(8) |-> port_slot[0] == SLOT_W'(rd_a_idx));

  // R4
  mid_user_chk: assert property (@(posedge clk) disable iff (rst)
    (mode != MD_FIQ && wr_idx >= IDX_W'(8) && wr_idx <= IDX_W'(12))
      |-> port_slot[2] == SLOT_W'(wr_idx));

  // R5
  pair_private_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == MD_IRQ && !user_bank && rd_b_idx == IDX_W'(13))
      |-> port_slot[1] != SLOT_W'(13));

endmodule

// File: tb/sim_banked_regfile.sv
`timescale 1ns/1ps
module sim_banked_regfile;
  typedef struct {
    bit          ca;
    logic [31:0] ea;
    bit          cb;
    logic [31:0] eb;
    bit          cs;
    logic [31:0] es;
    string       tag;
  } exp_t;

  localparam logic [4:0] U = 5'b10000, F = 5'b10001, I = 5'b10010, S = 5'b10011,
                         A = 5'b10111, D = 5'b11011, Y = 5'b11111;

  logic clk = 0, rst = 1;
  logic [4:0] mode = U;
  logic user_bank = 0;
  logic [3:0] rd_a_idx = 0, rd_b_idx = 0, wr_idx = 0;
  logic wr_en = 0, sr_wr_en = 0;
  logic [31:0] wr_data = 0, sr_wr_data = 0;
  logic [31:0] rd_a_data, rd_b_data, sr_rd_data;

  int checks = 0, fails = 0;
  bit done = 0, reported = 0;
  exp_t sb[$];

  always #4 clk = ~clk;

  banked_regfile u0 (
    .clk(clk), .rst(rst), .mode(mode), .user_bank(user_bank),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .sr_wr_en(sr_wr_en), .sr_wr_data(sr_wr_data), .sr_rd_data(sr_rd_data)
  );

  function automatic exp_t ex(bit ca, logic [31:0] ea, bit cb, logic [31:0] eb,
                              bit cs, logic [31:0] es, string t);
    exp_t e;
    e.ca = ca; e.ea = ea; e.cb = cb; e.eb = eb; e.cs = cs; e.es = es; e.tag = t;
    return e;
  endfunction

  task automatic drive(input logic [4:0] m, input bit ub, input logic [3:0] ra,
                       input logic [3:0] rb, input bit we, input logic [3:0] wi,
                       input logic [31:0] wd, input bit swe, input logic [31:0] swd,
                       input exp_t e);
    @(negedge clk);
    mode = m; user_bank = ub; rd_a_idx = ra; rd_b_idx = rb;
    wr_en = we; wr_idx = wi; wr_data = wd; sr_wr_en = swe; sr_wr_data = swd;
    sb.push_back(e);
  endtask

  task automatic wr(input logic [4:0] m, input bit ub, input logic [3:0] wi,
                    input logic [31:0] wd);
    drive(m, ub, 0, 0, 1, wi, wd, 0, 0, ex(0, 0, 0, 0, 0, 0, ""));
  endtask

  task automatic rd2(input logic [4:0] m, input bit ub, input logic [3:0] ra,
                     input logic [3:0] rb, input logic [31:0] ea,
                     input logic [31:0] eb, input string t);
    drive(m, ub, ra, rb, 0, 0, 0, 0, 0, ex(1, ea, 1, eb, 0, 0, t));
  endtask

  task automatic cmp(input string t, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", t, what, act, exp);
    end
  endtask

  // Monitor: results appear after the edge that follows each drive.
  initial begin
    forever begin
      @(posedge clk); #2;
      if (sb.size() != 0) begin
        exp_t e;
        e = sb.pop_front();
        if (e.ca) cmp(e.tag, "rd_a", rd_a_data, e.ea);
        if (e.cb) cmp(e.tag, "rd_b", rd_b_data, e.eb);
        if (e.cs) cmp(e.tag, "sr", sr_rd_data, e.es);
      end
    end
  end

  task automatic finish_run();
    if (!reported) begin
      reported = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    logic [4:0] xm [5] = '{F, I, S, A, D};
    // R1: outputs clear under reset
    drive(U, 0, 1, 2, 0, 0, 0, 0, 0, ex(1, 0, 1, 0, 1, 0, "R1"));
    drive(F, 0, 13, 15, 0, 0, 0, 0, 0, ex(1, 0, 1, 0, 1, 0, "R1"));
    @(negedge clk); rst = 0;

    for (int i = 0; i < 16; i++) wr(U, 0, 4'(i), 32'h1000_0000 + i);
    for (int i = 8; i < 15; i++) wr(F, 0, 4'(i), 32'h2000_0000 + i);
    for (int k = 1; k < 5; k++) begin
      wr(xm[k], 0, 13, 32'h1000_0000 * (k + 2) + 13);
      wr(xm[k], 0, 14, 32'h1000_0000 * (k + 2) + 14);
    end
    wr(I, 0, 0, 32'h7000_0000);

    rd2(U, 0, 0, 8, 32'h7000_0000, 32'h1000_0008, "R3/R2");
    rd2(F, 0, 8, 12, 32'h2000_0008, 32'h2000_000C, "R4");
    rd2(I, 0, 8, 12, 32'h1000_0008, 32'h1000_000C, "R4");
    rd2(F, 0, 13, 14, 32'h2000_000D, 32'h2000_000E, "R5");
    rd2(I, 0, 13, 14, 32'h3000_000D, 32'h3000_000E, "R5");
    rd2(S, 0, 13, 14, 32'h4000_000D, 32'h4000_000E, "R5");
    rd2(A, 0, 13, 14, 32'h5000_000D, 32'h5000_000E, "R5");
    rd2(D, 0, 13, 14, 32'h6000_000D, 32'h6000_000E, "R5");
    rd2(Y, 0, 13, 14, 32'h1000_000D, 32'h1000_000E, "R5");
    rd2(5'b00000, 0, 13, 14, 32'h1000_000D, 32'h1000_000E, "R7");
    rd2(5'b10110, 0, 8, 13, 32'h1000_0008, 32'h1000_000D, "R7");

    rd2(F, 0, 15, 15, 32'h1000_000F, 32'h1000_000F, "R6");
    wr(A, 0, 15, 32'hABCD_0123);
    rd2(U, 0, 15, 15, 32'hABCD_0123, 32'hABCD_0123, "R6");

    rd2(F, 1, 8, 13, 32'h1000_0008, 32'h1000_000D, "R8");
    wr(F, 1, 9, 32'h5555_5555);
    rd2(F, 0, 9, 9, 32'h2000_0009, 32'h2000_0009, "R8");
    rd2(U, 0, 9, 9, 32'h5555_5555, 32'h5555_5555, "R8");
    wr(S, 1, 14, 32'h6666_6666);
    rd2(U, 1, 14, 13, 32'h6666_6666, 32'h1000_000D, "R8");
    rd2(S, 0, 14, 14, 32'h4000_000E, 32'h4000_000E, "R8");
    wr(Y, 0, 14, 32'h7777_7777);
    rd2(U, 0, 14, 14, 32'h7777_7777, 32'h7777_7777, "R5");

    for (int k = 0; k < 5; k++)
      drive(xm[k], 0, 0, 0, 0, 0, 0, 1, 32'hF0 + k, ex(0, 0, 0, 0, 0, 0, ""));
    for (int k = 0; k < 5; k++)
      drive(xm[k], 0, 0, 0, 0, 0, 0, 0, 0, ex(0, 0, 0, 0, 1, 32'hF0 + k, "R9"));
    drive(U, 0, 0, 0, 0, 0, 0, 1, 32'hBAD, ex(0, 0, 0, 0, 1, 0, "R9"));
    drive(Y, 0, 0, 0, 0, 0, 0, 1, 32'hBAD, ex(0, 0, 0, 0, 1, 0, "R9"));
    drive(5'b00101, 0, 0, 0, 0, 0, 0, 1, 32'hBAD, ex(0, 0, 0, 0, 1, 0, "R7"));
    drive(A, 0, 0, 0, 0, 0, 0, 0, 0, ex(0, 0, 0, 0, 1, 32'hF3, "R9"));
    drive(S, 0, 0, 0, 0, 0, 0, 0, 0, ex(0, 0, 0, 0, 1, 32'hF2, "R9"));

    drive(S, 0, 13, 13, 1, 13, 32'h9999_9999, 1, 32'hA5,
          ex(1, 32'h4000_000D, 1, 32'h4000_000D, 1, 32'hF2, "R10"));
    drive(S, 0, 13, 13, 0, 0, 0, 0, 0,
          ex(1, 32'h9999_9999, 1, 32'h9999_9999, 1, 32'hA5, "R10"));

    repeat (3) @(negedge clk);
    done = 1;
    finish_run();
  end
endmodule